// File: doc/BRIEF.md
# Packed SIMD Integer Add/Logic Unit

This block runs one 64-bit packed integer operation per clock. The two operands are split into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed on its own: a carry, borrow or clamp in one lane never reaches its neighbour.

The arithmetic operations are add and subtract. Each comes in three overflow flavours: wraparound, unsigned saturation and signed saturation. The unit also has four bitwise logic operations. It has two lane compares, which write a full mask of ones or zeros into each lane.

An issuing stage presents the operands, an opcode and a lane-size code with a valid strobe. The registered result appears, with its own valid flag, after the next rising clock edge.

Top module: `simd_alu64`

## Requirements
- R1: `lane_sel` picks the lane width: 0 = 8-bit lanes, 1 = 16-bit lanes, 2 = 32-bit lanes, 3 = treated as 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: Opcode 0 (add) and opcode 3 (sub, a minus b) wrap modulo 2^W in each lane, and no carry or borrow crosses a lane boundary. For example, byte A0h plus 70h gives 10h.
- R3: Opcode 1 (add, unsigned saturate) clamps a lane to all ones on carry out. Opcode 4 (sub, unsigned saturate) clamps a lane to zero on borrow. For 16-bit lanes the limits are FFFFh and 0000h.
- R4: Opcodes 2 (add) and 5 (sub) use signed saturation. They clamp a lane to the largest positive value (7F..F) or the most negative value (80..0) in two's complement. With 8-bit lanes, 8080555580805555h plus 009033FF009033FFh gives 80807F5480807F54h.
- R5: Opcodes 6 (a AND b), 7 (a OR b), 8 (a XOR b) and 9 ((NOT a) AND b) act on all 64 bits, and their result does not depend on `lane_sel`.
- R6: Opcode 10 sets each lane to all ones when the two lanes are equal, and to all zeros otherwise.
- R7: Opcode 11 sets each lane to all ones when lane a is greater than lane b as a signed two's-complement value, and to all zeros otherwise.
- R8: `result` and `out_valid` update on the clock edge that samples `in_valid` high. A cycle with `in_valid` low drives `out_valid` low and leaves `result` unchanged.
- R9: A synchronous active-low reset clears `result` to zero and drops `out_valid`.
- R10: Opcodes 12 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | Operation code (see requirements) |
| lane_sel | input | 2 | Lane width code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered packed result |

## Verification
A fault inside one lane shows up only in that lane's bit field, in the cycle after the operation is issued. The bench therefore compares the whole 64-bit word against an independently computed lane model, so a lane that leaks a carry or clamps to the wrong limit is caught at once.

A wrong lane-width selection corrupts every lane boundary, and a stuck result register shows up on the next issued operation. A valid flag that lags or sticks is visible one cycle after any strobe change. The bench samples midway between edges to catch it.

// File: rtl/simd_pkg.sv
// Package: shared opcode and lane-size codes for the packed integer unit.
// Assumes a 4-bit opcode and a 2-bit lane-size field at the block edge.
package simd_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDUS = 4'd1,
        OP_ADDSS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBUS = 4'd4,
        OP_SUBSS = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_ANDN  = 4'd9,
        OP_CMPEQ = 4'd10,
        OP_CMPGT = 4'd11
    } simd_op_e;

    localparam logic [1:0] LSEL_8  = 2'd0;
    localparam logic [1:0] LSEL_16 = 2'd1;
    localparam logic [1:0] LSEL_32 = 2'd2;
    localparam int         NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane_alu.sv
// Module: one lane of packed add/sub/compare, W bits wide.
// Does wraparound, unsigned-saturating and signed-saturating add and sub,
// plus equal and signed greater-than masks. Logic opcodes give zero here;
// the top handles them. Purely combinational.
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  simd_op_e     op,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum;
    logic [W:0]   dif;
    logic         s_ovf_add;
    logic         s_ovf_sub;
    logic [W-1:0] s_lim;

    // Widened sum and difference, with the carry or borrow in the top bit.
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        dif = {1'b0, a} - {1'b0, b};
    end

    // Signed overflow detection and the clamp value, chosen by the sign of a.
    always_comb begin
        s_ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        s_ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        s_lim     = a[W-1] ? SMIN : SMAX;
    end

    // Lane result select per opcode.
    always_comb begin
        case (op)
            OP_ADD:   y = sum[W-1:0];
            OP_ADDUS: y = sum[W] ? ALL1 : sum[W-1:0];
            OP_ADDSS: y = s_ovf_add ? s_lim : sum[W-1:0];
            OP_SUB:   y = dif[W-1:0];
            OP_SUBUS: y = dif[W] ? '0 : dif[W-1:0];
            OP_SUBSS: y = s_ovf_sub ? s_lim : dif[W-1:0];
            OP_CMPEQ: y = (a == b) ? ALL1 : '0;
            OP_CMPGT: y = ($signed(a) > $signed(b)) ? ALL1 : '0;
            default:  y = '0;
        endcase
    end

    // Unsigned saturation never wraps: the sum is not below either input,
    // and the difference is not above the minuend.
    always_comb begin
        if (!$isunknown({a, b, op})) begin
            if (op == OP_ADDUS)
                assert_usat_add_R3: assert (y >= a && y >= b);
            if (op == OP_SUBUS)
                assert_usat_sub_R3: assert (y <= a);
        end
    end
endmodule

// File: rtl/simd_alu64.sv
// Module: top of the packed SIMD integer add/logic unit.
// Builds lane arrays for every lane width, selects one by lane_sel,
// handles the bitwise opcodes over the full word, and registers the
// result and valid flag. Assumes DATA_W is a multiple of 32.
// Reset is synchronous, active low.
module simd_alu64
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NBYTES = DATA_W / 8;

    simd_op_e                         op;
    logic [NUM_SIZES-1:0][DATA_W-1:0] lane_res;
    logic [DATA_W-1:0]                arith_res;
    logic [DATA_W-1:0]                next_res;

    assign op = simd_op_e'(opcode);

    // One lane array per lane width: 8, 16 and 32 bits.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        for (genvar k = 0; k < NL; k++) begin : g_lane
            simd_lane_alu #(.W(LW)) u_lane (
                .a  (src_a[k*LW +: LW]),
                .b  (src_b[k*LW +: LW]),
                .op (op),
                .y  (lane_res[g][k*LW +: LW])
            );
        end
    end

    // Pick the lane array for the requested width; code 3 acts as 32-bit.
    always_comb begin
        case (lane_sel)
            LSEL_8:  arith_res = lane_res[0];
            LSEL_16: arith_res = lane_res[1];
            default: arith_res = lane_res[2];
        endcase
    end

    // Final opcode decode: bitwise ops over the full word, lane ops from the array.
    always_comb begin
        case (op)
            OP_AND:  next_res = src_a & src_b;
            OP_OR:   next_res = src_a | src_b;
            OP_XOR:  next_res = src_a ^ src_b;
            OP_ANDN: next_res = ~src_a & src_b;
            OP_ADD, OP_ADDUS, OP_ADDSS, OP_SUB, OP_SUBUS, OP_SUBSS,
            OP_CMPEQ, OP_CMPGT:
                     next_res = arith_res;
            default: next_res = '0;
        endcase
    end

    // Output register: capture on a valid strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end

    // A valid strobe yields a valid result one edge later.
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // No strobe means no valid flag.
    assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // No strobe means the result register holds its value.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // Reset empties the output register.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !out_valid));

    // Inverted-first AND-NOT result.
    assert_andn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_ANDN) |=> result == (~$past(src_a) & $past(src_b)));

    // Undefined opcodes give zero.
    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode >= 4'd12) |=> result == '0);

    // A compare fills every byte with all ones or all zeros, for any lane width.
    for (genvar j = 0; j < NBYTES; j++) begin : g_mask_chk
        assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (opcode == OP_CMPEQ || opcode == OP_CMPGT)) |=>
            (result[j*8 +: 8] == 8'h00 || result[j*8 +: 8] == 8'hFF));
    end
endmodule

// File: tb/simd_alu64_test.sv
`timescale 1ns/1ps
module simd_alu64_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [1:0]  lane_sel = 2'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simd_alu64 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_sel(lane_sel), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    // Independent lane model written from the requirements.
    function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        longint m = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        if (op == 4'd6) return a & b;
        if (op == 4'd7) return a | b;
        if (op == 4'd8) return a ^ b;
        if (op == 4'd9) return ~a & b;
        if (op > 4'd11) return '0;
        for (int i = 0; i < 64 / w; i++) begin
            longint ua = longint'((a >> (i * w))) & m;
            longint ub = longint'((b >> (i * w))) & m;
            longint sa = (ua >= half) ? ua - (m + 1) : ua;
            longint sb = (ub >= half) ? ub - (m + 1) : ub;
            longint v;
            case (op)
                4'd0: v = ua + ub;
                4'd1: v = (ua + ub > m) ? m : ua + ub;
                4'd2: begin v = sa + sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                4'd3: v = ua - ub;
                4'd4: v = (ua < ub) ? 0 : ua - ub;
                4'd5: begin v = sa - sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                4'd10: v = (ua == ub) ? m : 0;
                default: v = (sa > sb) ? m : 0;
            endcase
            r = r | ((64'(v) & 64'(m)) << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check the registered result one edge later.
    task automatic run_op(input string req, input logic [3:0] op, input logic [1:0] sz,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        opcode = op; lane_sel = sz; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, model(op, sz, a, b));
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        check("R9 reset result", result, 64'd0);
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_known_vectors;
        run_op("R4 example", 4'd2, 2'd0, 64'h8080555580805555, 64'h009033FF009033FF);
        check("R4 literal", result, 64'h80807F5480807F54);
        run_op("R2 A0+70", 4'd0, 2'd0, 64'h00000000000000A0, 64'h0000000000000070);
        check("R2 literal", result, 64'h0000000000000010);
        run_op("R3 word usat add", 4'd1, 2'd1, 64'hFFF0_0001_8000_1234, 64'h0020_0001_8000_0001);
        check("R3 literal", result, 64'hFFFF_0002_FFFF_1235);
        run_op("R3 word usat sub", 4'd4, 2'd1, 64'h0001_0005_FFFF_0000, 64'h0002_0003_0001_0001);
        run_op("R4 word ssat", 4'd2, 2'd1, 64'h7FFF_8000_7000_9000, 64'h0001_FFFF_1000_F000);
        check("R4 clamp literal", result, 64'h7FFF_8000_7FFF_8000);
        run_op("R4 word ssat sub", 4'd5, 2'd1, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0003);
        run_op("R2 dword sub borrow", 4'd3, 2'd2, 64'h00000000_00000000, 64'h00000000_00000001);
        check("R2 no cross-lane borrow", result, 64'h00000000_FFFFFFFF);
        run_op("R1 sel3 as dword", 4'd0, 2'd3, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000001);
    endtask

    task automatic t_logic;
        for (int s = 0; s < 4; s++) begin
            run_op("R5 and", 4'd6, 2'(s), 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0F0F_0000);
            run_op("R5 andn", 4'd9, 2'(s), 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0F0F_0000);
            check("R5 andn literal", result, 64'h0F00_EDCB_0907_0000);
        end
        run_op("R5 or", 4'd7, 2'd0, 64'h1, 64'h8000_0000_0000_0000);
        run_op("R5 xor", 4'd8, 2'd1, 64'hAAAA, 64'hFFFF);
    endtask

    task automatic t_compare;
        run_op("R6 eq bytes", 4'd10, 2'd0, 64'h0102_0304_0506_0708, 64'h0102_0004_0506_0008);
        check("R6 literal", result, 64'hFFFF_00FF_FFFF_00FF);
        run_op("R7 gt signed words", 4'd11, 2'd1, 64'h8000_0001_7FFF_FFFF, 64'h7FFF_FFFF_8000_FFFF);
        check("R7 literal", result, 64'h0000_FFFF_FFFF_0000);
        run_op("R7 gt dword", 4'd11, 2'd2, 64'hFFFFFFFF_00000005, 64'h00000000_00000004);
    endtask

    task automatic t_undefined;
        for (int o = 12; o < 16; o++)
            run_op("R10 undefined opcode", 4'(o), 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        run_op("R8 setup", 4'd0, 2'd0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101);
        prev = result;
        @(negedge clk);
        src_a = 64'hDEAD_BEEF_0000_0000; opcode = 4'd8;
        @(negedge clk);
        check("R8 hold result", result, prev);
        check("R8 idle valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++)
            run_op("R1 random", 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                   {$urandom, $urandom}, {$urandom, $urandom});
    endtask

    task automatic t_reset_midrun;
        run_op("R9 pre", 4'd7, 2'd0, 64'h55, 64'hAA00);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R9 mid reset result", result, 64'd0);
        check("R9 mid reset valid", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_known_vectors();
        t_logic();
        t_compare();
        t_undefined();
        t_hold();
        t_random();
        t_reset_midrun();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule